// File: doc/BRIEF.md
# Auto-Increment Buffer Pointer

This block holds a host-writable pointer into packet buffer memory and turns data register accesses into memory requests. A pointer load sets an 11-bit offset plus three mode bits: an area bit that selects the packet number source (the head of the receive queue or the transmit packet number register), a direction bit that marks the following data accesses as reads or writes, and an auto-advance bit. Every memory address is the selected packet number placed above the offset.

In write mode, each data access becomes a memory write at the current address, carrying the host data and access size. In read mode, the data register is filled ahead of time: loading the pointer with the read bit high issues a prefetch, and each read access with auto-advance set prefetches the next location. A host access made while a prefetch is outstanding is held off by a wait signal until the memory returns data. With auto-advance set, the pointer moves forward by the access size after each access and wraps within the 2048-byte packet page.

Top module: `buf_ptr_top`

## Requirements
- R1: A pointer load with the read bit low updates offset and mode bits and issues no memory request.
- R2: With auto-advance set, an accepted access moves the offset forward by its size: code 00 (byte) by 1, 01 (word) by 2, 10 (double word) by 4, and code 11 is treated as a double word (by 4).
- R3: The offset wraps modulo 2048, so an advance past 2047 continues from the low end of the same page.
- R4: With auto-advance clear, the offset keeps its value across accesses, and a read access issues no further prefetch.
- R5: A memory address is {packet number, offset}; the packet number is rx_pkt when the area bit is set and tx_pkt when it is clear.
- R6: A pointer load with the read bit high drives a read request (mem_req high, mem_we low) at the newly loaded address on the next cycle, and acc_wait stays high from that cycle until mem_rvalid is returned.
- R7: In write mode an accepted access drives, on the next cycle, a write request at the address before the advance, carrying acc_wdata and acc_size.
- R8: In read mode an accepted access returns the data register on acc_rdata in its acceptance cycle; with auto-advance set it then prefetches the advanced location.
- R9: After reset no request is issued, acc_wait is low and the pointer is zero with all mode bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptr_wr | input | 1 | Pointer load strobe |
| ptr_off | input | 11 | Offset to load |
| ptr_rx | input | 1 | Area bit: 1 receive, 0 transmit |
| ptr_rd | input | 1 | Direction bit: 1 read, 0 write |
| ptr_auto | input | 1 | Auto-advance enable |
| acc_valid | input | 1 | Data register access, held until acc_wait is low |
| acc_size | input | 2 | Access size code (00 byte, 01 word, 10 double word) |
| acc_wdata | input | 32 | Write data for write-mode accesses |
| acc_wait | output | 1 | Access held off (prefetch outstanding or pointer load) |
| acc_rdata | output | 32 | Data register contents |
| tx_pkt | input | 6 | Transmit packet number register value |
| rx_pkt | input | 6 | Packet number at the head of the receive queue |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 17 | Request address {packet, offset} |
| mem_size | output | 2 | Request size code |
| mem_wdata | output | 32 | Request write data |
| mem_rvalid | input | 1 | Read data return strobe |
| mem_rdata | input | 32 | Read data |

## Verification
A wrong offset in this block shows up at the next memory request, one cycle after the access that produced it, as a mismatched low address field; a wrong area bit shows as the wrong packet number in the upper field of that same request. A lost or stale data register shows as wrong acc_rdata on the next accepted read, and a stuck prefetch-busy state shows as acc_wait never dropping, which the watchdog turns into a failure. A missing or extra prefetch is caught as an unexpected or absent request on the memory port.

// File: rtl/buf_ptr_pkg.sv
package buf_ptr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_DWORD = 2'b10,
    SZ_RSVD  = 2'b11
  } acc_size_e;

  function automatic logic [2:0] step_of(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: step_of = 3'd1;
      SZ_WORD: step_of = 3'd2;
      default: step_of = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/buf_ptr_step.sv
module buf_ptr_step
  import buf_ptr_pkg::*;
#(
  parameter int OFF_W = 11
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [1:0]       size_i,
  output logic [OFF_W-1:0] off_o
);
  logic [2:0] step;

  always_comb begin
    step  = step_of(size_i);
    off_o = off_i + OFF_W'(step);
  end
endmodule

// File: rtl/buf_ptr_addr.sv
module buf_ptr_addr #(
  parameter int PKT_W = 6,
  parameter int OFF_W = 11
) (
  input  logic                   rx_i,
  input  logic [PKT_W-1:0]       tx_pkt_i,
  input  logic [PKT_W-1:0]       rx_pkt_i,
  input  logic [OFF_W-1:0]       off_i,
  output logic [PKT_W+OFF_W-1:0] addr_o
);
  always_comb begin
    addr_o = {(rx_i ? rx_pkt_i : tx_pkt_i), off_i};
  end
endmodule

// File: rtl/buf_ptr_top.sv
module buf_ptr_top
  import buf_ptr_pkg::*;
#(
  parameter int PKT_W  = 6,
  parameter int OFF_W  = 11,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ptr_wr,
  input  logic [OFF_W-1:0]       ptr_off,
  input  logic                   ptr_rx,
  input  logic                   ptr_rd,
  input  logic                   ptr_auto,
  input  logic                   acc_valid,
  input  logic [1:0]             acc_size,
  input  logic [DATA_W-1:0]      acc_wdata,
  output logic                   acc_wait,
  output logic [DATA_W-1:0]      acc_rdata,
  input  logic [PKT_W-1:0]       tx_pkt,
  input  logic [PKT_W-1:0]       rx_pkt,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [PKT_W+OFF_W-1:0] mem_addr,
  output logic [1:0]             mem_size,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic                   mem_rvalid,
  input  logic [DATA_W-1:0]      mem_rdata
);
  localparam int ADDR_W = PKT_W + OFF_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  // state
  logic [OFF_W-1:0]  off_q, off_d;
  logic              rx_q, rx_d, rd_q, rd_d, auto_q, auto_d;
  logic              busy_q, busy_d;
  logic [DATA_W-1:0] dreg_q, dreg_d;
  logic              req_q, req_d, we_q, we_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [1:0]        size_q, size_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;

  logic [OFF_W-1:0]  off_inc;
  logic [ADDR_W-1:0] ld_addr, cur_addr, inc_addr;
  logic              accept;

  buf_ptr_step #(.OFF_W(OFF_W)) u_step (
    .off_i (off_q),
    .size_i(acc_size),
    .off_o (off_inc)
  );

  buf_ptr_addr #(.PKT_W(PKT_W), .OFF_W(OFF_W)) u_addr_ld (
    .rx_i(ptr_rx), .tx_pkt_i(tx_pkt), .rx_pkt_i(rx_pkt),
    .off_i(ptr_off), .addr_o(ld_addr)
  );

  buf_ptr_addr #(.PKT_W(PKT_W), .OFF_W(OFF_W)) u_addr_cur (
    .rx_i(rx_q), .tx_pkt_i(tx_pkt), .rx_pkt_i(rx_pkt),
    .off_i(off_q), .addr_o(cur_addr)
  );

  buf_ptr_addr #(.PKT_W(PKT_W), .OFF_W(OFF_W)) u_addr_inc (
    .rx_i(rx_q), .tx_pkt_i(tx_pkt), .rx_pkt_i(rx_pkt),
    .off_i(off_inc), .addr_o(inc_addr)
  );

  assign acc_wait = busy_q | ptr_wr;
  assign accept   = acc_valid & ~acc_wait;

  // next state
  always_comb begin
    off_d   = off_q;
    rx_d    = rx_q;
    rd_d    = rd_q;
    auto_d  = auto_q;
    busy_d  = busy_q;
    dreg_d  = dreg_q;
    req_d   = 1'b0;
    we_d    = we_q;
    addr_d  = addr_q;
    size_d  = size_q;
    wdata_d = wdata_q;

    if (mem_rvalid && busy_q) begin
      dreg_d = mem_rdata;
      busy_d = 1'b0;
    end

    if (ptr_wr) begin
      off_d  = ptr_off;
      rx_d   = ptr_rx;
      rd_d   = ptr_rd;
      auto_d = ptr_auto;
      if (ptr_rd) begin
        req_d  = 1'b1;
        we_d   = 1'b0;
        addr_d = ld_addr;
        size_d = SZ_DWORD;
        busy_d = 1'b1;
      end
    end else if (accept) begin
      if (auto_q) off_d = off_inc;
      if (rd_q) begin
        if (auto_q) begin
          req_d  = 1'b1;
          we_d   = 1'b0;
          addr_d = inc_addr;
          size_d = SZ_DWORD;
          busy_d = 1'b1;
        end
      end else begin
        req_d   = 1'b1;
        we_d    = 1'b1;
        addr_d  = cur_addr;
        size_d  = acc_size;
        wdata_d = acc_wdata;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      off_q   <= '0;
      rx_q    <= 1'b0;
      rd_q    <= 1'b0;
      auto_q  <= 1'b0;
      busy_q  <= 1'b0;
      dreg_q  <= '0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      size_q  <= SZ_BYTE;
      wdata_q <= '0;
    end else begin
      off_q   <= off_d;
      rx_q    <= rx_d;
      rd_q    <= rd_d;
      auto_q  <= auto_d;
      busy_q  <= busy_d;
      dreg_q  <= dreg_d;
      req_q   <= req_d;
      we_q    <= we_d;
      addr_q  <= addr_d;
      size_q  <= size_d;
      wdata_q <= wdata_d;
    end
  end

  assign acc_rdata = dreg_q;
  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_size  = size_q;
  assign mem_wdata = wdata_q;
endmodule

// File: rtl/buf_ptr_chk.sv
module buf_ptr_chk #(
  parameter int PKT_W = 6,
  parameter int OFF_W = 11
) (
  input logic                   clk,
  input logic                   rst_ni,
  input logic                   ptr_wr,
  input logic [OFF_W-1:0]       ptr_off,
  input logic                   ptr_rx,
  input logic                   ptr_rd,
  input logic                   acc_valid,
  input logic                   acc_wait,
  input logic [PKT_W-1:0]       tx_pkt,
  input logic [PKT_W-1:0]       rx_pkt,
  input logic                   mem_req,
  input logic                   mem_we,
  input logic [PKT_W+OFF_W-1:0] mem_addr,
  input logic                   rd_q,
  input logic                   auto_q,
  input logic [OFF_W-1:0]       off_q
);
  localparam int ADDR_W = PKT_W + OFF_W;

  p_no_prefetch_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    ptr_wr && !ptr_rd |=> !mem_req);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_valid && !acc_wait && !auto_q |=> $stable(off_q));

  p_area_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    ptr_wr && ptr_rd |=>
      mem_addr[ADDR_W-1:OFF_W] == ($past(ptr_rx) ? $past(rx_pkt) : $past(tx_pkt)));

  p_prefetch_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    ptr_wr && ptr_rd |=> mem_req && !mem_we && mem_addr[OFF_W-1:0] == $past(ptr_off));

  p_wait_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req && !mem_we |-> acc_wait);

  p_write_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    acc_valid && !acc_wait && !rd_q |=> mem_req && mem_we);
endmodule

bind buf_ptr_top buf_ptr_chk #(.PKT_W(PKT_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_ni(rst_s_n), .ptr_wr(ptr_wr), .ptr_off(ptr_off),
  .ptr_rx(ptr_rx), .ptr_rd(ptr_rd), .acc_valid(acc_valid), .acc_wait(acc_wait),
  .tx_pkt(tx_pkt), .rx_pkt(rx_pkt), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .rd_q(rd_q), .auto_q(auto_q), .off_q(off_q)
);

// File: tb/tb_buf_ptr_top.sv
module tb_buf_ptr_top;
  localparam int CLK_P = 10;

  logic        clk, rst_n;
  logic        ptr_wr, ptr_rx, ptr_rd, ptr_auto;
  logic [10:0] ptr_off;
  logic        acc_valid;
  logic [1:0]  acc_size;
  logic [31:0] acc_wdata, acc_rdata;
  logic        acc_wait;
  logic [5:0]  tx_pkt, rx_pkt;
  logic        mem_req, mem_we, mem_rvalid;
  logic [16:0] mem_addr;
  logic [1:0]  mem_size;
  logic [31:0] mem_wdata, mem_rdata;

  buf_ptr_top dut (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_off(ptr_off),
    .ptr_rx(ptr_rx), .ptr_rd(ptr_rd), .ptr_auto(ptr_auto),
    .acc_valid(acc_valid), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_wait(acc_wait), .acc_rdata(acc_rdata), .tx_pkt(tx_pkt), .rx_pkt(rx_pkt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;

  typedef struct packed {
    logic        we;
    logic [16:0] addr;
    logic [31:0] wdata;
    logic [1:0]  size;
  } req_t;

  req_t  exp_q[$];
  string tag_q[$];

  // model state
  logic [10:0] m_off;
  logic        m_rx, m_rd, m_auto;

  function automatic logic [31:0] mfun(input logic [16:0] a);
    return {~a[14:0], a};
  endfunction

  function automatic logic [16:0] maddr(input logic rx, input logic [10:0] off);
    return {(rx ? rx_pkt : tx_pkt), off};
  endfunction

  function automatic logic [10:0] mstep(input logic [1:0] sz);
    return (sz == 2'b00) ? 11'd1 : (sz == 2'b01) ? 11'd2 : 11'd4;
  endfunction

  // memory model and request monitor
  logic        pend;
  logic [16:0] pend_addr;
  always @(negedge clk) begin
    cycles++;
    mem_rvalid <= 1'b0;
    if (pend) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mfun(pend_addr);
      pend       <= 1'b0;
    end
    if (rst_n && mem_req) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected request actual we=%0b addr=%h expected none", mem_we, mem_addr);
      end else begin
        req_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (mem_we !== e.we || mem_addr !== e.addr ||
            (e.we && (mem_wdata !== e.wdata || mem_size !== e.size))) begin
          errors++;
          $display("FAIL %s request actual we=%0b addr=%h data=%h size=%0d expected we=%0b addr=%h data=%h size=%0d",
                   t, mem_we, mem_addr, mem_wdata, mem_size, e.we, e.addr, e.wdata, e.size);
        end
      end
      if (!mem_we) begin
        pend      <= 1'b1;
        pend_addr <= mem_addr;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input logic we, input logic [16:0] a,
                      input logic [31:0] d, input logic [1:0] sz);
    req_t e;
    e.we = we; e.addr = a; e.wdata = d; e.size = sz;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic load_ptr(input string tag, input logic [10:0] off, input logic rx,
                          input logic rd, input logic au);
    @(negedge clk);
    ptr_wr = 1'b1; ptr_off = off; ptr_rx = rx; ptr_rd = rd; ptr_auto = au;
    m_off = off; m_rx = rx; m_rd = rd; m_auto = au;
    if (rd) push(tag, 1'b0, maddr(rx, off), '0, 2'b10);
    @(negedge clk);
    ptr_wr = 1'b0;
    if (rd) check("R6 wait after read load", {31'd0, acc_wait}, 32'd1);
  endtask

  task automatic do_write(input string tag, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_size = sz; acc_wdata = d;
    while (acc_wait) @(negedge clk);
    push(tag, 1'b1, maddr(m_rx, m_off), d, sz);
    if (m_auto) m_off = m_off + mstep(sz);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic do_read(input string tag, input logic [1:0] sz);
    @(negedge clk);
    acc_valid = 1'b1; acc_size = sz;
    while (acc_wait) @(negedge clk);
    check(tag, acc_rdata, mfun(maddr(m_rx, m_off)));
    if (m_auto) begin
      m_off = m_off + mstep(sz);
      push(tag, 1'b0, maddr(m_rx, m_off), '0, 2'b10);
    end
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // watchdog
  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ptr_wr = 0; ptr_off = '0; ptr_rx = 0; ptr_rd = 0; ptr_auto = 0;
    acc_valid = 0; acc_size = 0; acc_wdata = '0; tx_pkt = 6'h15; rx_pkt = 6'h2A;
    mem_rvalid = 0; mem_rdata = '0; pend = 0; pend_addr = '0;
    m_off = '0; m_rx = 0; m_rd = 0; m_auto = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 wait low after reset", {31'd0, acc_wait}, 32'd0);
    check("R9 no request after reset", {31'd0, mem_req}, 32'd0);
    check("R9 data register cleared", acc_rdata, 32'd0);

    // R1 write-mode load issues nothing; R2 R5 R7 transmit-area writes with each size
    load_ptr("R1", 11'd10, 1'b0, 1'b0, 1'b1);
    do_write("R7 byte write", 2'b00, 32'h1111_0001);
    do_write("R2 word write", 2'b01, 32'h2222_0002);
    do_write("R2 dword write", 2'b10, 32'h3333_0003);
    do_write("R2 reserved size as dword", 2'b11, 32'h4444_0004);
    do_write("R5 transmit area", 2'b00, 32'h5555_0005);

    // R3 wrap within the page
    load_ptr("R3", 11'd2046, 1'b0, 1'b0, 1'b1);
    do_write("R3 write at 2046", 2'b10, 32'h6666_0006);
    do_write("R3 write after wrap", 2'b00, 32'h7777_0007);

    // R4 no advance with auto-advance clear
    load_ptr("R4", 11'd100, 1'b1, 1'b0, 1'b0);
    do_write("R4 first write", 2'b01, 32'h8888_0008);
    do_write("R4 second write same addr", 2'b01, 32'h9999_0009);

    // R6 R8 R5 receive-area reads with auto-advance
    load_ptr("R6 prefetch on load", 11'd40, 1'b1, 1'b1, 1'b1);
    do_read("R8 word read", 2'b01);
    do_read("R8 byte read", 2'b00);
    do_read("R5 dword read receive area", 2'b10);

    // R4 R8 reads without auto-advance
    load_ptr("R6 prefetch transmit", 11'd7, 1'b0, 1'b1, 1'b0);
    do_read("R8 read hold first", 2'b10);
    do_read("R4 read hold second", 2'b10);

    repeat (10) @(negedge clk);
    check("R8 all expected requests seen", exp_q.size(), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule